// File: doc/BRIEF.md
# SPI Controller Register Front End

This block sits between a CPU register bus and the shift engine of an 8-bit SPI controller. It holds the status flags and the transmit byte for the engine, and it returns the received byte to software. A write to the data address hands a byte to the engine with a one-cycle start pulse. A read of the data address returns whatever byte the engine has assembled. The status address reports two sticky flags. One is a transfer-complete flag. The other is a write-collision flag, raised when software writes a byte while the engine is still shifting.

The flags are cleared by a handshake instead of by a write. Software first reads status and sees a flag set, which arms the clear. Its next access to the data address, read or write, then clears the flags. The complete flag can also be cleared by acknowledging its interrupt. A master that finds its slave-select input pulled low also sets the complete flag, so software can detect that another master has taken the bus.

Top module: `spi_reg_frontend`

## Requirements
- R1: Address 0 is status and address 1 is data. A status read returns {done, coll, 000000}, with done in bit 7 and coll in bit 6. `bus_rdata` is registered: it updates on the edge that samples a read and holds between reads. After reset, status reads 0x00, `irq_req` is 0 and `eng_start` is 0.
- R2: A data write while not busy raises `eng_start` for exactly one cycle after the write edge and loads `eng_tx_byte` with the written byte on that same edge.
- R3: The block is busy while `eng_busy` is high or its own start pulse is high. A data write while busy sets coll, gives no start pulse and leaves `eng_tx_byte` unchanged.
- R4: A one-cycle `eng_done` pulse sets done, and the next status read shows it.
- R5: Every cycle that `cfg_master`, `ss_dir_in` and a low `ss_level` hold together sets done. A low `ss_level` sets nothing when `cfg_master` or `ss_dir_in` is low.
- R6: `irq_req` is high one cycle after done is set while both `irq_en` and `glb_irq_en` are high. Otherwise it is low.
- R7: `irq_ack` clears done and leaves coll unchanged.
- R8: A status read that sees done set arms a clear, and the next data access clears done. A data access that no such status read armed leaves the flags as they are.
- R9: A status read that sees coll set arms a clear of both flags, which the next data access performs. Any data access disarms.
- R10: A flag set by a new event in the same cycle as its clearing access stays set.
- R11: A data read returns `eng_rx_byte` as sampled on the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Register address: 0 status, 1 data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| eng_busy | input | 1 | Shift engine is transferring |
| eng_done | input | 1 | Transfer finished pulse |
| eng_rx_byte | input | 8 | Received byte from the engine |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_tx_byte | output | 8 | Byte to transmit |
| cfg_master | input | 1 | Controller is in master mode |
| ss_dir_in | input | 1 | Slave-select pin is configured as an input |
| ss_level | input | 1 | Slave-select pin level |
| irq_en | input | 1 | SPI interrupt enable |
| glb_irq_en | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq_req | output | 1 | Interrupt request |

## Verification
A wrong arm bit shows up as a flag that survives its data access. It can be seen on the status read that follows, and a stuck done flag also shows one cycle later on `irq_req`. A busy view that leaves out the block's own start pulse lets a second write go straight through: the bench sees a second `eng_start` and a changed `eng_tx_byte` on the very next edge, where a collision should have been reported. A clear that takes priority over a new event loses the flag, and the next status read shows it missing.

// File: rtl/spi_fe_pkg.sv
`timescale 1ns/1ps
package spi_fe_pkg;
  // Decoded bus strobes for one cycle
  typedef struct packed {
    logic rd_stat;
    logic rd_data;
    logic wr_data;
  } bus_hit_t;

  function automatic logic data_touch(bus_hit_t h);
    return h.rd_data | h.wr_data;
  endfunction
endpackage

// File: rtl/spi_fe_decode.sv
`timescale 1ns/1ps
module spi_fe_decode
  import spi_fe_pkg::*;
#(
  parameter int ADDR_W = 1,
  parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(1)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output bus_hit_t          hit
);
  always_comb begin
    hit.rd_stat = rd && (addr == STAT_ADDR);
    hit.rd_data = rd && (addr == DATA_ADDR);
    hit.wr_data = wr && (addr == DATA_ADDR);
  end
endmodule

// File: rtl/spi_fe_txport.sv
`timescale 1ns/1ps
module spi_fe_txport #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wdata,
  input  logic              eng_busy,
  output logic              start_q,
  output logic [DATA_W-1:0] tx_q,
  output logic              coll_evt
);
  logic busy_eff;
  logic accept;

  // The engine raises busy only after it sees the start pulse, so the pulse counts as busy too
  always_comb begin
    busy_eff = eng_busy | start_q;
    accept   = wr_data & ~busy_eff;
    coll_evt = wr_data & busy_eff;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      tx_q    <= '0;
    end else begin
      start_q <= accept;
      if (accept) tx_q <= wdata;
    end
  end

  // R2: the start pulse lasts exactly one cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);
  // R3: no start while the engine reports busy
  a_r3_busy_blocks_start: assert property (@(posedge clk) disable iff (rst)
    eng_busy |=> !start_q);
  // R3: the transmit byte only moves with a start
  a_r3_tx_hold: assert property (@(posedge clk) disable iff (rst)
    !start_q |-> $stable(tx_q));
endmodule

// File: rtl/spi_fe_flags.sv
`timescale 1ns/1ps
module spi_fe_flags (
  input  logic clk,
  input  logic rst,
  input  logic rd_stat,
  input  logic touch,
  input  logic coll_evt,
  input  logic done_evt,
  input  logic irq_ack,
  output logic done_q,
  output logic coll_q
);
  logic arm_done, arm_coll;
  logic clr_done, clr_coll;

  always_comb begin
    clr_coll = touch & arm_coll;
    clr_done = (touch & (arm_done | arm_coll)) | irq_ack;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q   <= 1'b0;
      coll_q   <= 1'b0;
      arm_done <= 1'b0;
      arm_coll <= 1'b0;
    end else begin
      // new events win over clears
      done_q <= done_evt | (done_q & ~clr_done);
      coll_q <= coll_evt | (coll_q & ~clr_coll);
      if (touch) begin
        arm_done <= 1'b0;
        arm_coll <= 1'b0;
      end else if (rd_stat) begin
        arm_done <= done_q;
        arm_coll <= coll_q;
      end
    end
  end

  // R10: an event always leaves its flag set
  a_r10_done_event_wins: assert property (@(posedge clk) disable iff (rst)
    done_evt |=> done_q);
  a_r10_coll_event_wins: assert property (@(posedge clk) disable iff (rst)
    coll_evt |=> coll_q);
  // R7 R8: done falls only after an acknowledge or a data access
  a_r8_done_clear_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(done_q) |-> $past(irq_ack || touch));
  // R9: coll falls only after a data access
  a_r9_coll_clear_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(coll_q) |-> $past(touch));
endmodule

// File: rtl/spi_fe_readback.sv
`timescale 1ns/1ps
module spi_fe_readback #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stat,
  input  logic              rd_data,
  input  logic              done_q,
  input  logic              coll_q,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              ien,
  input  logic              gie,
  output logic [DATA_W-1:0] rdata_q,
  output logic              irq_q
);
  localparam int DONE_BIT = DATA_W - 1;
  localparam int COLL_BIT = DATA_W - 2;

  logic [DATA_W-1:0] stat_word;

  always_comb begin
    stat_word           = '0;
    stat_word[DONE_BIT] = done_q;
    stat_word[COLL_BIT] = coll_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= done_q & ien & gie;
      if (rd_stat)      rdata_q <= stat_word;
      else if (rd_data) rdata_q <= rx_byte;
    end
  end

  // R1: the low status bits read as zero
  a_r1_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rd_stat) |-> (rdata_q[COLL_BIT-1:0] == '0));
  // R6: the global enable gates the request
  a_r6_gie_gates: assert property (@(posedge clk) disable iff (rst)
    !gie |=> !irq_q);
  a_r6_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(done_q));
endmodule

// File: rtl/spi_reg_frontend.sv
`timescale 1ns/1ps
module spi_reg_frontend
  import spi_fe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 1,
  parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic [DATA_W-1:0] eng_rx_byte,
  output logic              eng_start,
  output logic [DATA_W-1:0] eng_tx_byte,
  input  logic              cfg_master,
  input  logic              ss_dir_in,
  input  logic              ss_level,
  input  logic              irq_en,
  input  logic              glb_irq_en,
  input  logic              irq_ack,
  output logic              irq_req
);
  bus_hit_t hit;
  logic     coll_evt, done_evt, mode_fault;
  logic     done_q, coll_q;

  spi_fe_decode #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .hit(hit)
  );

  spi_fe_txport #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .wr_data(hit.wr_data), .wdata(bus_wdata),
    .eng_busy(eng_busy), .start_q(eng_start), .tx_q(eng_tx_byte), .coll_evt(coll_evt)
  );

  // R5: another master pulling slave-select low counts as a completion
  always_comb begin
    mode_fault = cfg_master & ss_dir_in & ~ss_level;
    done_evt   = eng_done | mode_fault;
  end

  spi_fe_flags u_flags (
    .clk(clk), .rst(rst), .rd_stat(hit.rd_stat), .touch(data_touch(hit)),
    .coll_evt(coll_evt), .done_evt(done_evt), .irq_ack(irq_ack),
    .done_q(done_q), .coll_q(coll_q)
  );

  spi_fe_readback #(.DATA_W(DATA_W)) u_rb (
    .clk(clk), .rst(rst), .rd_stat(hit.rd_stat), .rd_data(hit.rd_data),
    .done_q(done_q), .coll_q(coll_q), .rx_byte(eng_rx_byte),
    .ien(irq_en), .gie(glb_irq_en), .rdata_q(bus_rdata), .irq_q(irq_req)
  );

  // R4: a done pulse is visible as the request one cycle after the flag
  a_r4_done_to_irq: assert property (@(posedge clk) disable iff (rst)
    eng_done && irq_en && glb_irq_en ##1 irq_en && glb_irq_en |=> irq_req);
endmodule

// File: tb/spi_reg_frontend_bench.sv
`timescale 1ns/1ps
module spi_reg_frontend_bench;
  localparam logic [2:0] OP_IDLE = 3'd0, OP_RSTAT = 3'd1, OP_RDATA = 3'd2,
                         OP_WDATA = 3'd3, OP_DONE = 3'd4, OP_ACK = 3'd5, OP_BUSY = 3'd6;

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] wd;
    logic       chk;
    logic [7:0] rd;
    logic       irq;
  } vec_t;

  // op, write data, check rdata, expected rdata, expected irq (one cycle after the op)
  localparam vec_t VEC [16] = '{
    '{OP_RSTAT, 8'h00, 1'b1, 8'h00, 1'b0},  // R1 clean status
    '{OP_WDATA, 8'hA5, 1'b0, 8'h00, 1'b0},  // R2 accepted write
    '{OP_BUSY,  8'h00, 1'b0, 8'h00, 1'b0},
    '{OP_WDATA, 8'h3C, 1'b0, 8'h00, 1'b0},  // R3 collision
    '{OP_RSTAT, 8'h00, 1'b1, 8'h40, 1'b0},  // R3 coll in bit 6
    '{OP_DONE,  8'h00, 1'b0, 8'h40, 1'b1},  // R4 R6 done sets irq
    '{OP_RSTAT, 8'h00, 1'b1, 8'hC0, 1'b1},  // R9 arm both
    '{OP_RDATA, 8'h00, 1'b1, 8'h5A, 1'b0},  // R9 R11 clear both
    '{OP_RSTAT, 8'h00, 1'b1, 8'h00, 1'b0},
    '{OP_DONE,  8'h00, 1'b0, 8'h00, 1'b1},
    '{OP_RDATA, 8'h00, 1'b1, 8'h5A, 1'b1},  // R8 unarmed access keeps done
    '{OP_RSTAT, 8'h00, 1'b1, 8'h80, 1'b1},  // R8 arm done
    '{OP_WDATA, 8'h11, 1'b0, 8'h80, 1'b0},  // R8 write access clears
    '{OP_DONE,  8'h00, 1'b0, 8'h80, 1'b1},
    '{OP_ACK,   8'h00, 1'b0, 8'h80, 1'b0},  // R7 ack clears done
    '{OP_RSTAT, 8'h00, 1'b1, 8'h00, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [0:0] bus_addr = 1'b0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       eng_busy = 1'b0, eng_done = 1'b0;
  logic [7:0] eng_rx_byte = 8'h5A;
  logic       eng_start;
  logic [7:0] eng_tx_byte;
  logic       cfg_master = 1'b0, ss_dir_in = 1'b0, ss_level = 1'b1;
  logic       irq_en = 1'b1, glb_irq_en = 1'b1, irq_ack = 1'b0;
  logic       irq_req;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  spi_reg_frontend u_spi_reg_frontend (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_busy(eng_busy),
    .eng_done(eng_done), .eng_rx_byte(eng_rx_byte), .eng_start(eng_start),
    .eng_tx_byte(eng_tx_byte), .cfg_master(cfg_master), .ss_dir_in(ss_dir_in),
    .ss_level(ss_level), .irq_en(irq_en), .glb_irq_en(glb_irq_en),
    .irq_ack(irq_ack), .irq_req(irq_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge with strobes dropped
  task automatic op(input logic [2:0] o, input logic [7:0] d);
    case (o)
      OP_RSTAT: begin bus_addr = 1'b0; bus_rd = 1'b1; end
      OP_RDATA: begin bus_addr = 1'b1; bus_rd = 1'b1; end
      OP_WDATA: begin bus_addr = 1'b1; bus_wr = 1'b1; bus_wdata = d; end
      OP_DONE:  begin eng_done = 1'b1; eng_busy = 1'b0; end
      OP_ACK:   irq_ack = 1'b1;
      OP_BUSY:  eng_busy = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; eng_done = 1'b0; irq_ack = 1'b0;
  endtask

  task automatic stat_is(input string tag, input logic [7:0] exp);
    op(OP_RSTAT, 8'h00);
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset rdata", bus_rdata, 8'h00);
    check("R1 reset irq", irq_req, 1'b0);
    check("R1 reset start", eng_start, 1'b0);

    for (int i = 0; i < 16; i++) begin
      op(VEC[i].op, VEC[i].wd);
      @(negedge clk);
      if (VEC[i].chk)
        check($sformatf("R1 R8 R9 R11 table step %0d rdata", i), bus_rdata, VEC[i].rd);
      check($sformatf("R4 R6 R7 table step %0d irq", i), irq_req, VEC[i].irq);
    end

    // R2 start pulse and transmit byte
    bus_addr = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h77;
    @(negedge clk);
    check("R2 start high", eng_start, 1'b1);
    check("R2 tx loaded", eng_tx_byte, 8'h77);
    // R3 write right behind, before the engine reports busy
    bus_wdata = 8'h88;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R3 no second start", eng_start, 1'b0);
    check("R3 tx unchanged", eng_tx_byte, 8'h77);
    stat_is("R3 coll flag", 8'h40);
    op(OP_RDATA, 8'h00);
    stat_is("R9 cleared", 8'h00);

    // R5 mode fault
    cfg_master = 1'b1; ss_dir_in = 1'b1; ss_level = 1'b0;
    @(negedge clk);
    ss_level = 1'b1;
    stat_is("R5 fault sets done", 8'h80);
    op(OP_ACK, 8'h00);
    cfg_master = 1'b0; ss_level = 1'b0;
    @(negedge clk);
    ss_level = 1'b1;
    stat_is("R5 slave mode ignores ss", 8'h00);
    cfg_master = 1'b1; ss_dir_in = 1'b0; ss_level = 1'b0;
    @(negedge clk);
    ss_level = 1'b1; cfg_master = 1'b0;
    stat_is("R5 output ss ignored", 8'h00);

    // R10 done event with clearing access
    op(OP_DONE, 8'h00);
    stat_is("R10 armed", 8'h80);
    bus_addr = 1'b1; bus_rd = 1'b1; eng_done = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; eng_done = 1'b0;
    stat_is("R10 done survives", 8'h80);
    op(OP_RDATA, 8'h00);
    stat_is("R8 cleared", 8'h00);
    // R10 collision with clearing access
    op(OP_BUSY, 8'h00);
    op(OP_WDATA, 8'h21);
    stat_is("R10 coll set", 8'h40);
    op(OP_WDATA, 8'h22);
    stat_is("R10 coll survives", 8'h40);
    check("R3 tx after rejected writes", eng_tx_byte, 8'h77);

    // R7 ack leaves coll
    op(OP_DONE, 8'h00);
    op(OP_ACK, 8'h00);
    stat_is("R7 coll kept done cleared", 8'h40);
    op(OP_RDATA, 8'h00);
    stat_is("R9 clear after ack", 8'h00);

    // R6 enable gating
    op(OP_DONE, 8'h00);
    glb_irq_en = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R6 gie low", irq_req, 1'b0);
    glb_irq_en = 1'b1; irq_en = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R6 ien low", irq_req, 1'b0);
    irq_en = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R6 both high", irq_req, 1'b1);
    op(OP_ACK, 8'h00);

    // R11 receive byte readback
    eng_rx_byte = 8'hC3;
    op(OP_RDATA, 8'h00);
    check("R11 rx byte", bus_rdata, 8'hC3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule